// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

This block sits beside a 16-bit timer counter and watches its count. It holds a 16-bit compare value that a processor loads and reads over an 8-bit bus, one byte at a time. A single 8-bit staging register carries the upper byte, so a whole 16-bit value changes in one cycle. The unit compares the count with its active compare value on every clock. When the two are equal, it sets a flag one cycle later, and that flag can raise an interrupt request.

The counter supplies an operating mode. In the two non-PWM modes a committed value reaches the comparator at once. In the PWM modes a committed value waits in a buffer. It is copied to the active register only when the counter signals either the top or the bottom of its sequence, and an input chooses which of the two. The active value is also driven out, so the counter can use it as its period limit.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the active value, the buffer, the staging byte and the flag are all zero, so `top_val`, `flag` and `irq` read zero.
- R2: A 16-bit write goes high byte first. A write to address 1 only loads the staging byte and leaves the compare value unchanged. A write to address 0 commits {staging, data} as one 16-bit value.
- R3: A 16-bit read goes low byte first. Reading address 0 returns the low byte of the buffered value and copies its high byte into staging. Reading address 1 then returns the staging byte. Address 2 reads the flag in bit 0, with the other bits zero.
- R4: In mode 0 (normal) and mode 1 (match-clear), a commit changes `top_val` at the same clock edge.
- R5: In modes 2 and 3 (PWM), a commit reaches only the buffer. `top_val` stays unchanged until an update point.
- R6: In PWM modes, with `upd_at_top`=1 the buffer is copied on an `at_top` pulse and `at_bottom` is ignored. With `upd_at_top`=0 the copy happens on `at_bottom` and `at_top` is ignored.
- R7: When `cnt` equals the active value at a clock edge, the flag is not yet set after that edge. It is set after the following edge.
- R8: `irq` is high exactly when the flag is set and `irq_en` is 1.
- R9: The flag clears on an `irq_ack` pulse or on a write of 1 to bit 0 of address 2. Writing 0 there leaves the flag as it was.
- R10: If a set and a clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from current state |
| cnt | input | 16 | Timer count |
| mode | input | 2 | 0 normal, 1 match-clear, 2/3 PWM |
| at_top | input | 1 | Counter is at its top this cycle |
| at_bottom | input | 1 | Counter is at its bottom this cycle |
| upd_at_top | input | 1 | PWM update point: 1 top, 0 bottom |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt serviced, clears flag |
| flag | output | 1 | Compare match flag |
| irq | output | 1 | Interrupt request |
| top_val | output | 16 | Active compare value |

## Verification
The hardest case to reach is a set and a clear of the flag in the same cycle. To reach it, the stimulus holds the count equal to the compare value. The match then repeats every cycle, and the clear is written while it persists. Checks at the ports cover the flag delay, the byte order of both access paths, and which update point copies the PWM buffer. For the update point, the active value is observed through `top_val` around separate top and bottom pulses.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned HI_W   = CNT_W - BUS_W;

    typedef enum logic [1:0] {
        ADDR_LO   = 2'd0,
        ADDR_HI   = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_NONE = 2'd3
    } cmp_addr_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_MCLR   = 2'd1,
        MODE_PWM_A  = 2'd2,
        MODE_PWM_B  = 2'd3
    } cmp_mode_e;

    function automatic logic mode_is_pwm(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/tmr_cmp_access.sv
module tmr_cmp_access
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned DW = CNT_W,
    parameter int unsigned BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    input  logic [DW-1:0] buf_val,
    input  logic          flag_val,
    output logic [BW-1:0] bus_rdata,
    output logic          commit,
    output logic [DW-1:0] commit_val,
    output logic          flag_clr
);
    localparam int unsigned HW = DW - BW;

    typedef struct packed {
        logic [HW-1:0] stage;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        commit     = 1'b0;
        flag_clr   = 1'b0;
        commit_val = {st_q.stage, bus_wdata};
        bus_rdata  = '0;
        if (bus_wr) begin
            unique case (cmp_addr_e'(bus_addr))
                ADDR_HI:   st_d.stage = bus_wdata[HW-1:0];
                ADDR_LO:   commit     = 1'b1;
                ADDR_FLAG: flag_clr   = bus_wdata[0];
                default:   ;
            endcase
        end else if (bus_rd) begin
            unique case (cmp_addr_e'(bus_addr))
                ADDR_LO:   st_d.stage = buf_val[DW-1:BW];
                default:   ;
            endcase
        end
        unique case (cmp_addr_e'(bus_addr))
            ADDR_LO:   bus_rdata = buf_val[BW-1:0];
            ADDR_HI:   bus_rdata = BW'(st_q.stage);
            ADDR_FLAG: bus_rdata = BW'(flag_val);
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HI_WRITE_HOLDS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> st_q.stage == $past(bus_wdata[HW-1:0])); // R2
    AST_LO_READ_LATCHES_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 2'd0) |=> st_q.stage == $past(buf_val[DW-1:BW])); // R3
endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned DW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          commit,
    input  logic [DW-1:0] commit_val,
    input  logic          at_top,
    input  logic          at_bottom,
    input  logic          upd_at_top,
    output logic [DW-1:0] buf_val,
    output logic [DW-1:0] act_val
);
    typedef struct packed {
        logic [DW-1:0] bufv;
        logic [DW-1:0] act;
    } regs_t;

    regs_t r_d, r_q;
    logic  pwm;
    logic  upd_hit;

    always_comb begin
        pwm     = mode_is_pwm(mode);
        upd_hit = upd_at_top ? at_top : at_bottom;
        r_d     = r_q;
        if (commit) r_d.bufv = commit_val;
        if (pwm) begin
            if (upd_hit) r_d.act = r_q.bufv;
        end else if (commit) begin
            r_d.act = commit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign buf_val = r_q.bufv;
    assign act_val = r_q.act;

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !mode[1]) |=> act_val == $past(commit_val)); // R4
    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !(upd_at_top ? at_top : at_bottom)) |=> $stable(act_val)); // R5
    AST_COPY_AT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && (upd_at_top ? at_top : at_bottom)) |=> act_val == $past(buf_val)); // R6
endmodule

// File: rtl/tmr_cmp_flag.sv
module tmr_cmp_flag
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned DW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] act_val,
    input  logic          sw_clr,
    input  logic          ack,
    output logic          flag
);
    typedef struct packed {
        logic eq;
        logic flg;
    } flag_t;

    flag_t f_d, f_q;

    always_comb begin
        f_d.eq  = (cnt == act_val);
        f_d.flg = f_q.flg;
        if (sw_clr || ack) f_d.flg = 1'b0;
        if (f_q.eq)        f_d.flg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flag = f_q.flg;

    AST_SET_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.flg) |-> $past(f_q.eq)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.eq |=> f_q.flg); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !f_q.eq) |=> !f_q.flg); // R9
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned DW = CNT_W,
    parameter int unsigned BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic [DW-1:0] cnt,
    input  logic [1:0]    mode,
    input  logic          at_top,
    input  logic          at_bottom,
    input  logic          upd_at_top,
    input  logic          irq_en,
    input  logic          irq_ack,
    output logic          flag,
    output logic          irq,
    output logic [DW-1:0] top_val
);
    logic          commit;
    logic [DW-1:0] commit_val;
    logic          flag_clr;
    logic [DW-1:0] buf_val;
    logic [DW-1:0] act_val;

    tmr_cmp_access #(.DW(DW), .BW(BW)) u_access (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .buf_val(buf_val),
        .flag_val(flag), .bus_rdata(bus_rdata), .commit(commit),
        .commit_val(commit_val), .flag_clr(flag_clr)
    );

    tmr_cmp_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .commit(commit),
        .commit_val(commit_val), .at_top(at_top), .at_bottom(at_bottom),
        .upd_at_top(upd_at_top), .buf_val(buf_val), .act_val(act_val)
    );

    tmr_cmp_flag #(.DW(DW)) u_flag (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .act_val(act_val),
        .sw_clr(flag_clr), .ack(irq_ack), .flag(flag)
    );

    assign irq     = flag & irq_en;
    assign top_val = act_val;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && flag)); // R8
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && bus_wr && bus_addr == 2'd2 && !bus_wdata[0] && !irq_ack) |=> flag); // R9
endmodule

// File: tb/tmr_cmp_unit_tb.sv
module tmr_cmp_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt = 16'hFFFF;
    logic [1:0]  mode = 2'd0;
    logic        at_top = 1'b0, at_bottom = 1'b0, upd_at_top = 1'b1;
    logic        irq_en = 1'b0, irq_ack = 1'b0;
    logic        flag, irq;
    logic [15:0] top_val;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .mode(mode), .at_top(at_top), .at_bottom(at_bottom),
        .upd_at_top(upd_at_top), .irq_en(irq_en), .irq_ack(irq_ack),
        .flag(flag), .irq(irq), .top_val(top_val)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic pulse_top();
        @(negedge clk); at_top = 1'b1;
        @(negedge clk); at_top = 1'b0;
    endtask

    task automatic pulse_bottom();
        @(negedge clk); at_bottom = 1'b1;
        @(negedge clk); at_bottom = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 top_val", top_val, 16'h0000);
        chk("R1 flag", {15'd0, flag}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        rd(2'd0, d);
        chk("R1 low byte", {8'd0, d}, 16'h0000);
    endtask

    task automatic t_write_normal();
        mode = 2'd0;
        wr(2'd1, 8'h12);
        chk("R2 high only no commit", top_val, 16'h0000);
        wr(2'd0, 8'h34);
        chk("R2 R4 commit normal", top_val, 16'h1234);
    endtask

    task automatic t_read_order();
        logic [7:0] d;
        wr(2'd1, 8'h77);
        rd(2'd0, d);
        chk("R3 low read", {8'd0, d}, 16'h0034);
        rd(2'd1, d);
        chk("R3 high read after latch", {8'd0, d}, 16'h0012);
    endtask

    task automatic t_match_flag();
        @(negedge clk); cnt = 16'h1234;
        @(negedge clk);
        chk("R7 flag not yet", {15'd0, flag}, 16'd0);
        cnt = 16'hFFFF;
        @(negedge clk);
        chk("R7 flag set", {15'd0, flag}, 16'd1);
    endtask

    task automatic t_irq_and_clear();
        logic [7:0] d;
        irq_en = 1'b0; #1;
        chk("R8 irq masked", {15'd0, irq}, 16'd0);
        irq_en = 1'b1; #1;
        chk("R8 irq raised", {15'd0, irq}, 16'd1);
        wr(2'd2, 8'h00);
        chk("R9 write 0 no effect", {15'd0, flag}, 16'd1);
        rd(2'd2, d);
        chk("R3 flag read", {8'd0, d}, 16'h0001);
        wr(2'd2, 8'h01);
        chk("R9 write 1 clears", {15'd0, flag}, 16'd0);
        #1;
        chk("R8 irq drops", {15'd0, irq}, 16'd0);
        @(negedge clk); cnt = 16'h1234;
        @(negedge clk); cnt = 16'hFFFF;
        @(negedge clk);
        chk("R7 flag set again", {15'd0, flag}, 16'd1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R9 ack clears", {15'd0, flag}, 16'd0);
        irq_en = 1'b0;
    endtask

    task automatic t_set_wins();
        @(negedge clk); cnt = 16'h1234;
        @(negedge clk);
        @(negedge clk);
        wr(2'd2, 8'h01);
        chk("R10 set beats clear", {15'd0, flag}, 16'd1);
        cnt = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        wr(2'd2, 8'h01);
        chk("R9 clear after match ends", {15'd0, flag}, 16'd0);
    endtask

    task automatic t_pwm_top();
        logic [7:0] d;
        mode = 2'd2; upd_at_top = 1'b1;
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h66);
        chk("R5 pwm hold", top_val, 16'h1234);
        rd(2'd0, d);
        chk("R3 reads buffer", {8'd0, d}, 16'h0066);
        pulse_bottom();
        chk("R6 bottom ignored", top_val, 16'h1234);
        pulse_top();
        chk("R6 copy at top", top_val, 16'h5566);
    endtask

    task automatic t_pwm_bottom();
        mode = 2'd3; upd_at_top = 1'b0;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h02);
        chk("R5 pwm hold b", top_val, 16'h5566);
        pulse_top();
        chk("R6 top ignored", top_val, 16'h5566);
        pulse_bottom();
        chk("R6 copy at bottom", top_val, 16'h0102);
    endtask

    task automatic t_mclr();
        mode = 2'd1;
        wr(2'd1, 8'h0A);
        wr(2'd0, 8'h0B);
        chk("R4 match-clear write through", top_val, 16'h0A0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_normal();
        t_read_order();
        t_match_flag();
        t_irq_and_clear();
        t_set_wins();
        t_pwm_top();
        t_pwm_bottom();
        t_mclr();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule